// File: doc/BRIEF.md
# Path BIP-8 Verifier with Error Counters

This block sits on the receive side of a path overhead processor. It takes a byte stream of synchronous payload envelopes (SPEs). Three marker strobes travel with each byte. One marks the first byte of an SPE, one marks the byte that carries the path parity (B3), and one marks the path status byte (G1). The block forms an even-parity BIP-8 over every valid byte of an SPE, leaving out the B3 byte itself. It holds that result until the B3 byte of the following SPE arrives and then compares the two. The SPE received first after reset has nothing before it, so it produces no check.

Two 16-bit saturating counters record the results. One counts near-end B3 errors and the other counts far-end REI-P errors, taken from the upper nibble of G1. Each counter has two counting modes, chosen by a bit of `mode_ctrl`. Each check also sends an REI-P value back to the transmit side. A B3 mismatch sets a sticky status bit, and that bit can pull an active-low interrupt. Software reads the counters through a snapshot strobe. The strobe latches both counters into read registers and restarts the counters in the same cycle.

Top module: `path_bip_checker`

## Requirements
- R1: The parity of an SPE is the XOR of all bytes taken with `in_valid` high, from its start strobe up to the next start strobe, not counting bytes flagged by `b3_mark`. That parity is checked against the byte flagged by `b3_mark` in the following SPE. No check takes place until a complete SPE has been received after reset, so `rei_tx_valid` stays low during the first SPE.
- R2: With `mode_ctrl[0]`=1 (B3 per-SPE mode), the B3 counter adds exactly 1 for each check that mismatches in any bit position.
- R3: With `mode_ctrl[0]`=0 (B3 per-bit mode), the B3 counter adds the number of mismatching bit positions, which is 0 to 8 per check.
- R4: With `mode_ctrl[1]`=0 (REI value mode), the REI counter adds the REI-P nibble. The nibble is `in_data[7:4]` of the byte flagged by `g1_mark`. A nibble value above 8 counts as 0.
- R5: With `mode_ctrl[1]`=1 (REI per-SPE mode), the REI counter adds 1 for each G1 byte whose nibble is nonzero after values above 8 are mapped to 0.
- R6: One cycle after each check, `rei_tx_valid` pulses high for one cycle. In the same cycle `rei_tx_val` presents 1 or 0 (mismatch or not) in per-SPE mode, or the number of errored bits in per-bit mode. `rei_tx_val` holds that value between checks.
- R7: A mismatching check sets `irq_stat[7]` on the next cycle. The bit stays set until a cycle that has `stat_rd_clr` and no new mismatch. A mismatch wins over a clear in the same cycle. All other status bits read 0.
- R8: `irq_n` is low exactly when `irq_stat[7]` is set and `irq_en` was high at the same update edge.
- R9: Both counters saturate at 65535 and never wrap.
- R10: On `cnt_snap`, each read register receives its counter's value as it was before that edge. The counter restarts at the increment that arrived in the same cycle, so no event is lost.
- R11: After synchronous reset both read registers, `rei_tx_val`, `rei_tx_valid` and `irq_stat` are 0, and `irq_n` is 1.
- R12: Bytes and marker strobes presented with `in_valid` low have no effect on parity, checks or counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Byte qualifier |
| in_data | input | 8 | Received SPE byte |
| spe_start | input | 1 | Byte is the first of an SPE |
| b3_mark | input | 1 | Byte is the path parity byte |
| g1_mark | input | 1 | Byte is the path status byte |
| mode_ctrl | input | 2 | Bit 0: B3 per-SPE mode; bit 1: REI per-SPE mode |
| irq_en | input | 1 | Interrupt enable for the B3 status bit |
| stat_rd_clr | input | 1 | Clear strobe for the sticky status |
| cnt_snap | input | 1 | Snapshot-and-clear strobe for both counters |
| b3_err_snap | output | 16 | Latched B3 error count |
| rei_err_snap | output | 16 | Latched REI-P error count |
| rei_tx_val | output | 4 | REI-P value for the transmit side |
| rei_tx_valid | output | 1 | One-cycle pulse per check |
| irq_stat | output | 8 | Sticky status, bit 7 = B3 error seen |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest condition to reach from the ports is a mismatch with an exact number of bit errors. The stimulus has to know the parity of the SPE before the current one. The bench keeps its own running XOR of the bytes it sends and writes the B3 byte as that parity XOR a chosen flip mask, so every check produces a known error weight. Counter saturation needs more than 65535 counted events. The bench reaches it with a long run of four-byte SPEs, each carrying eight flipped bits and an REI nibble of 8. Idle cycles carry random data and random marker strobes with `in_valid` low, and they are mixed into the traffic to show that unqualified strobes do nothing.

// File: rtl/path_bip_pkg.sv
package path_bip_pkg;
  localparam int BIP_W  = 8;
  localparam int ERRC_W = $clog2(BIP_W + 1);
  localparam int REI_W  = 4;

  function automatic logic [ERRC_W-1:0] bit_count(input logic [BIP_W-1:0] v);
    logic [ERRC_W-1:0] s;
    s = '0;
    for (int i = 0; i < BIP_W; i++) s = s + ERRC_W'(v[i]);
    return s;
  endfunction
endpackage

// File: rtl/bip_accum.sv
module bip_accum
  import path_bip_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [BIP_W-1:0] in_data,
  input  logic             spe_start,
  input  logic             b3_mark,
  output logic             chk_fire,
  output logic [BIP_W-1:0] err_mask
);
  logic [BIP_W-1:0] acc, prev_bip, ref_bip;
  logic             have_acc, prev_ok, ref_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      prev_bip <= '0;
      have_acc <= 1'b0;
      prev_ok  <= 1'b0;
    end else if (in_valid) begin
      if (spe_start) begin
        prev_bip <= acc;
        prev_ok  <= have_acc;
        have_acc <= 1'b1;
        acc      <= b3_mark ? '0 : in_data;
      end else if (have_acc && !b3_mark) begin
        acc <= acc ^ in_data;
      end
    end
  end

  // A B3 byte that shares its cycle with a start strobe checks the SPE just closed
  always_comb begin
    ref_bip  = spe_start ? acc : prev_bip;
    ref_ok   = spe_start ? have_acc : prev_ok;
    chk_fire = in_valid && b3_mark && ref_ok;
    err_mask = in_data ^ ref_bip;
  end

  // R1: a finished SPE only becomes checkable at a qualified start strobe
  p_prev_from_start_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(prev_ok) |-> $past(in_valid && spe_start));
endmodule

// File: rtl/err_counter.sv
module err_counter #(
  parameter int CW = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          add_en,
  input  logic [IW-1:0] add_val,
  input  logic          snap,
  output logic [CW-1:0] snap_val
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] cnt, add_ext, nxt;
  logic [CW:0]   sum;

  always_comb begin
    add_ext = add_en ? CW'(add_val) : '0;
    sum     = {1'b0, cnt} + {1'b0, add_ext};
    nxt     = sum[CW] ? CMAX : sum[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      snap_val <= '0;
    end else if (snap) begin
      snap_val <= cnt;
      cnt      <= add_ext;
    end else begin
      cnt <= nxt;
    end
  end

  p_sat_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt == CMAX && !snap) |=> cnt == CMAX);
  p_no_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    !snap |=> cnt >= $past(cnt));
  p_snap_capture_r10: assert property (@(posedge clk) disable iff (rst)
    snap |=> snap_val == $past(cnt));
endmodule

// File: rtl/irq_status.sv
module irq_status #(
  parameter int SW = 8,
  parameter int EB = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set,
  input  logic          rd_clr,
  input  logic          irq_en,
  output logic [SW-1:0] stat,
  output logic          irq_n
);
  logic [SW-1:0] stat_nxt;

  always_comb begin
    stat_nxt = stat;
    if (set)         stat_nxt[EB] = 1'b1;
    else if (rd_clr) stat_nxt[EB] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat  <= '0;
      irq_n <= 1'b1;
    end else begin
      stat  <= stat_nxt;
      irq_n <= ~|(stat_nxt & {SW{irq_en}});
    end
  end

  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (stat[EB] && !rd_clr) |=> stat[EB]);
  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    set |=> stat[EB]);
  p_irq_needs_stat_r8: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> stat[EB]);
endmodule

// File: rtl/path_bip_checker.sv
module path_bip_checker
  import path_bip_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int NIB_LIMIT = 8,
  parameter int STAT_W    = 8,
  parameter int B3_BIT    = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BIP_W-1:0]  in_data,
  input  logic              spe_start,
  input  logic              b3_mark,
  input  logic              g1_mark,
  input  logic [1:0]        mode_ctrl,
  input  logic              irq_en,
  input  logic              stat_rd_clr,
  input  logic              cnt_snap,
  output logic [CNT_W-1:0]  b3_err_snap,
  output logic [CNT_W-1:0]  rei_err_snap,
  output logic [REI_W-1:0]  rei_tx_val,
  output logic              rei_tx_valid,
  output logic [STAT_W-1:0] irq_stat,
  output logic              irq_n
);
  logic             chk_fire, any_err, g1_fire;
  logic [BIP_W-1:0] err_mask;
  logic [ERRC_W-1:0] b3_add;
  logic [REI_W-1:0] nib, nib_ok, rei_add;

  bip_accum u_accum (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .spe_start(spe_start), .b3_mark(b3_mark),
    .chk_fire(chk_fire), .err_mask(err_mask)
  );

  always_comb begin
    any_err = |err_mask;
    b3_add  = mode_ctrl[0] ? ERRC_W'(any_err) : bit_count(err_mask);
    g1_fire = in_valid && g1_mark;
    nib     = in_data[BIP_W-1 -: REI_W];
    nib_ok  = (int'(nib) > NIB_LIMIT) ? '0 : nib;
    rei_add = mode_ctrl[1] ? REI_W'(|nib_ok) : nib_ok;
  end

  err_counter #(.CW(CNT_W), .IW(ERRC_W)) u_b3_cnt (
    .clk(clk), .rst(rst), .add_en(chk_fire), .add_val(b3_add),
    .snap(cnt_snap), .snap_val(b3_err_snap)
  );

  err_counter #(.CW(CNT_W), .IW(REI_W)) u_rei_cnt (
    .clk(clk), .rst(rst), .add_en(g1_fire), .add_val(rei_add),
    .snap(cnt_snap), .snap_val(rei_err_snap)
  );

  irq_status #(.SW(STAT_W), .EB(B3_BIT)) u_stat (
    .clk(clk), .rst(rst), .set(chk_fire && any_err), .rd_clr(stat_rd_clr),
    .irq_en(irq_en), .stat(irq_stat), .irq_n(irq_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rei_tx_val   <= '0;
      rei_tx_valid <= 1'b0;
    end else begin
      rei_tx_valid <= chk_fire;
      if (chk_fire) rei_tx_val <= REI_W'(b3_add);
    end
  end

  p_tx_source_r6: assert property (@(posedge clk) disable iff (rst)
    rei_tx_valid |-> $past(in_valid && b3_mark));
  p_tx_per_spe_r2: assert property (@(posedge clk) disable iff (rst)
    (rei_tx_valid && $past(mode_ctrl[0])) |-> rei_tx_val <= 1);
  p_tx_range_r3: assert property (@(posedge clk) disable iff (rst)
    rei_tx_valid |-> rei_tx_val <= BIP_W);
endmodule

// File: tb/path_bip_checker_bench.sv
module path_bip_checker_bench;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0, rst = 1'b1;
  logic        in_valid = 0, spe_start = 0, b3_mark = 0, g1_mark = 0;
  logic [7:0]  in_data = 0;
  logic [1:0]  mode_ctrl = 0;
  logic        irq_en = 0, stat_rd_clr = 0, cnt_snap = 0;
  logic [15:0] b3_err_snap, rei_err_snap;
  logic [3:0]  rei_tx_val;
  logic        rei_tx_valid, irq_n;
  logic [7:0]  irq_stat;

  path_bip_checker u_path_bip_checker (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .spe_start(spe_start), .b3_mark(b3_mark), .g1_mark(g1_mark),
    .mode_ctrl(mode_ctrl), .irq_en(irq_en), .stat_rd_clr(stat_rd_clr),
    .cnt_snap(cnt_snap), .b3_err_snap(b3_err_snap), .rei_err_snap(rei_err_snap),
    .rei_tx_val(rei_tx_val), .rei_tx_valid(rei_tx_valid),
    .irq_stat(irq_stat), .irq_n(irq_n)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, n_txv = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_acc, m_prev, m_b3, m_rei, m_b3s, m_reis, m_tx;
  bit m_have, m_pok, m_txv, m_st, m_irqn;

  always @(posedge clk) begin
    if (rst) begin
      m_acc = 0; m_prev = 0; m_have = 0; m_pok = 0;
      m_b3 = 0; m_rei = 0; m_b3s = 0; m_reis = 0; m_tx = 0;
      m_txv = 0; m_st = 0; m_irqn = 1;
    end else begin
      int refb, em, bits, b3inc, reiinc, nib;
      bit rok, fire;
      refb  = spe_start ? m_acc : m_prev;
      rok   = spe_start ? m_have : m_pok;
      fire  = in_valid && b3_mark && rok;
      em    = (int'(in_data) ^ refb) & 255;
      bits  = $countones(em);
      b3inc = fire ? (mode_ctrl[0] ? int'(em != 0) : bits) : 0;
      nib   = int'(in_data) >> 4;
      if (nib > 8) nib = 0;
      reiinc = (in_valid && g1_mark) ? (mode_ctrl[1] ? int'(nib != 0) : nib) : 0;
      if (in_valid) begin
        if (spe_start) begin
          m_prev = m_acc; m_pok = m_have; m_have = 1;
          m_acc = b3_mark ? 0 : int'(in_data);
        end else if (m_have && !b3_mark) m_acc = m_acc ^ int'(in_data);
      end
      if (cnt_snap) begin
        m_b3s = m_b3; m_reis = m_rei; m_b3 = b3inc; m_rei = reiinc;
      end else begin
        m_b3  = (m_b3 + b3inc > 65535) ? 65535 : m_b3 + b3inc;
        m_rei = (m_rei + reiinc > 65535) ? 65535 : m_rei + reiinc;
      end
      m_txv = fire;
      if (fire) m_tx = mode_ctrl[0] ? int'(em != 0) : bits;
      if (fire && em != 0) m_st = 1;
      else if (stat_rd_clr) m_st = 0;
      m_irqn = !(m_st && irq_en);
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R10 b3 snapshot", b3_err_snap, m_b3s);
      chk("R10 rei snapshot", rei_err_snap, m_reis);
      chk("R6 tx valid", rei_tx_valid, m_txv);
      chk("R6 tx value", rei_tx_val, m_tx);
      chk("R7 status", irq_stat, m_st ? 128 : 0);
      chk("R8 irq", irq_n, m_irqn);
      if (rei_tx_valid) n_txv++;
    end
  end

  // Stimulus
  int s_prev = 0;

  task automatic idle(bit noisy);
    in_valid = 0; in_data = 8'($urandom);
    spe_start = noisy ? 1'($urandom) : 1'b0;
    b3_mark   = noisy ? 1'($urandom) : 1'b0;
    g1_mark   = noisy ? 1'($urandom) : 1'b0;
    @(negedge clk);
    spe_start = 0; b3_mark = 0; g1_mark = 0;
  endtask

  task automatic send_spe(int len, int flip, int g1, bit gaps);
    int cur = 0;
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom % 3 == 0)) idle(1);
      in_valid = 1; spe_start = (i == 0); b3_mark = (i == 1); g1_mark = (i == 2);
      if (i == 1)      in_data = 8'(s_prev ^ flip);
      else if (i == 2) in_data = 8'(g1);
      else             in_data = 8'($urandom);
      if (i != 1) cur = cur ^ int'(in_data);
      @(negedge clk);
    end
    in_valid = 0; spe_start = 0; b3_mark = 0; g1_mark = 0;
    s_prev = cur;
  endtask

  task automatic snap_read(output int b3v, output int reiv);
    cnt_snap = 1; @(negedge clk); cnt_snap = 0;
    b3v = b3_err_snap; reiv = rei_err_snap;
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int b, r;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R11 b3 snap", b3_err_snap, 0);
    chk("R11 rei snap", rei_err_snap, 0);
    chk("R11 tx", rei_tx_val + rei_tx_valid, 0);
    chk("R11 stat", irq_stat, 0);
    chk("R11 irq_n", irq_n, 1);

    // per-bit B3, REI value mode
    mode_ctrl = 2'b00; irq_en = 1;
    send_spe(12, 8'hFF, 8'h30, 0);
    chk("R1 first SPE unchecked", n_txv, 0);
    snap_read(b, r);
    send_spe(12, 8'h01, 8'h50, 0);
    chk("R1 second SPE checked", n_txv, 1);
    send_spe(12, 8'h07, 8'h80, 0);
    send_spe(12, 8'hFF, 8'h90, 0);
    send_spe(12, 8'h00, 8'hF0, 0);
    idle(0);
    snap_read(b, r);
    chk("R3 per-bit count", b, 12);
    chk("R4 nibble value count", r, 13);
    chk("R7 status set", irq_stat[7], 1);
    chk("R8 irq low", irq_n, 0);

    stat_rd_clr = 1; @(negedge clk); stat_rd_clr = 0;
    chk("R7 status cleared", irq_stat[7], 0);
    chk("R8 irq released", irq_n, 1);
    irq_en = 0;
    send_spe(10, 8'h20, 8'h00, 0);
    idle(0);
    chk("R8 masked irq", irq_n, 1);
    chk("R7 masked status", irq_stat[7], 1);
    irq_en = 1;
    stat_rd_clr = 1; @(negedge clk); stat_rd_clr = 0;

    // per-SPE modes
    mode_ctrl = 2'b11;
    snap_read(b, r);
    send_spe(9, 8'hFF, 8'h90, 0);
    send_spe(9, 8'h10, 8'h10, 0);
    send_spe(9, 8'h00, 8'h00, 0);
    send_spe(9, 8'h81, 8'h80, 0);
    idle(0);
    snap_read(b, r);
    chk("R2 per-SPE count", b, 3);
    chk("R5 per-SPE rei count", r, 2);

    // unqualified strobes ignored
    mode_ctrl = 2'b00;
    send_spe(8, 8'h00, 8'h00, 0);
    snap_read(b, r);
    send_spe(10, 8'h03, 8'h20, 1);
    send_spe(10, 8'h03, 8'h20, 1);
    repeat (4) idle(1);
    snap_read(b, r);
    chk("R12 gaps b3", b, 4);
    chk("R12 gaps rei", r, 4);

    // saturation
    for (int k = 0; k < 8200; k++) send_spe(4, 8'hFF, 8'h80, 0);
    idle(0);
    snap_read(b, r);
    chk("R9 b3 saturates", b, 65535);
    chk("R9 rei saturates", r, 65535);
    send_spe(4, 8'hFF, 8'h80, 0);
    idle(0);
    snap_read(b, r);
    chk("R10 restart after clear b3", b, 8);
    chk("R10 restart after clear rei", r, 8);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule